// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Atomic Set and Clear

This block is a parameterised general-purpose I/O port that a host reaches through a minimal register bus. The bus has a two-bit word address, a write strobe, write data and registered read data. Every register is as wide as the port, and the port has one pin for each register bit. The pins appear as three vectors: an output value, an output enable and a raw input. Any bus bridge, tri-state pad or pin multiplexer lives outside the block.

A host can drive all outputs at once through the data word. It can also change chosen pins without a read-modify-write by writing a mask to the set word or to the clear word. A direction word decides which pins drive. Three build-time parameters shape the port:
- whether a 1 in the direction word means "drive" or "receive";
- whether pin 0 sits at the least or the most significant register bit;
- whether the port has a direction word at all. Without one, every pin is bidirectional and always enabled.

Inputs are resynchronised before the host can see them.

Top module: `mmgpio_port`

## Requirements
- R1: While reset is high and on the first cycle after it, the output register and the direction register hold all zeros, so `pin_out` is zero. `bus_rdata` reads zero after reset.
- R2: A write to word offset 0 (data) replaces every output bit with `bus_wdata`. The new value shows on `pin_out` after that clock edge. When no write occurs, `pin_out` holds its value.
- R3: A write to word offset 1 (set) forces to 1 each output bit whose mask bit is 1. Output bits whose mask bit is 0 keep their value.
- R4: A write to word offset 2 (clear) forces to 0 each output bit whose mask bit is 1. Output bits whose mask bit is 0 keep their value.
- R5: Reads of offsets 1 and 2 return zero. Writes to those offsets leave the direction word and `pin_oe` unchanged.
- R6: When DIR_IS_INPUT=0, a 1 in the direction word (offset 3) enables the pin's output. When DIR_IS_INPUT=1, a 1 makes the pin an input, so the output enable is the inverse bit. With DIR_IS_INPUT=1, reset leaves every pin driving.
- R7: A read of offset 0 returns, in each bit, the driven output value if that pin is an output. If the pin is an input, the bit returns its synchronised input.
- R8: A change on `pin_in` that is stable before clock edge k reaches `bus_rdata` at edge k+2 when offset 0 is addressed. After edge k+1, `bus_rdata` still shows the old value.
- R9: When MSB_FIRST=1, pin n corresponds to register bit WIDTH-1-n for data, set, clear, direction and read-back. When MSB_FIRST=0, pin n corresponds to bit n.
- R10: When HAS_DIR=0, `pin_oe` is all ones and offset 0 reads return the synchronised inputs. Offset 3 reads zero, and writes to offset 3 have no effect.
- R11: When HAS_DIR=1, a read of offset 3 returns the direction word last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Word offset: 0 data, 1 set, 2 clear, 3 direction |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | WIDTH | Write data or bit mask |
| bus_rdata | output | WIDTH | Read data for the offset addressed in the previous cycle |
| pin_in | input | WIDTH | Raw pin inputs, asynchronous to clk |
| pin_out | output | WIDTH | Output value for each pin |
| pin_oe | output | WIDTH | Output enable for each pin |

## Verification
The bench builds three 8-bit ports side by side on a shared bus:
- one with default ordering and a direction word where 1 means drive;
- one bit-reversed with a direction word where 1 means receive;
- one without a direction word.

At 8 bits, every possible data word and every possible direction word can be swept, each with set and clear masks derived from the data value. Both polarities and both pin orderings can then be compared, value by value, against arithmetic expectations. Mixed input and output read-back and the two-stage input latency are checked on chosen patterns.

// File: rtl/mmgpio_pkg.sv
package mmgpio_pkg;
  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    SEL_DATA = 2'd0,
    SEL_SET  = 2'd1,
    SEL_CLR  = 2'd2,
    SEL_DIR  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mmgpio_order.sv
// Maps between pin order and register bit order; the mapping is its own inverse.
module mmgpio_order #(
  parameter int unsigned WIDTH   = 8,
  parameter bit          REVERSE = 1'b0
) (
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] dst
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (REVERSE) begin : g_rev
      assign dst[i] = src[WIDTH-1-i];
    end else begin : g_fwd
      assign dst[i] = src[i];
    end
  end
endmodule

// File: rtl/mmgpio_sync.sv
module mmgpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mmgpio_regs.sv
module mmgpio_regs
  import mmgpio_pkg::*;
#(
  parameter int unsigned WIDTH   = 8,
  parameter bit          HAS_DIR = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else if (wr) begin
      case (sel)
        SEL_DATA: out_q <= wdata;
        SEL_SET:  out_q <= out_q | wdata;
        SEL_CLR:  out_q <= out_q & ~wdata;
        default:  out_q <= out_q;
      endcase
    end
  end

  if (HAS_DIR) begin : g_dir
    always_ff @(posedge clk) begin
      if (rst) begin
        dir_q <= '0;
      end else if (wr && sel == SEL_DIR) begin
        dir_q <= wdata;
      end
    end
  end else begin : g_nodir
    assign dir_q = '0;
  end
endmodule

// File: rtl/mmgpio_port.sv
module mmgpio_port
  import mmgpio_pkg::*;
#(
  parameter int unsigned WIDTH        = 8,
  parameter bit          DIR_IS_INPUT = 1'b0,
  parameter bit          MSB_FIRST    = 1'b0,
  parameter bit          HAS_DIR      = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic                  bus_wr,
  input  logic [WIDTH-1:0]      bus_wdata,
  output logic [WIDTH-1:0]      bus_rdata,
  input  logic [WIDTH-1:0]      pin_in,
  output logic [WIDTH-1:0]      pin_out,
  output logic [WIDTH-1:0]      pin_oe
);
  localparam int unsigned SYNC_STAGES = 2;

  reg_sel_e         sel;
  logic [WIDTH-1:0] out_q, dir_q;
  logic [WIDTH-1:0] in_sync, in_reg;
  logic [WIDTH-1:0] drive_reg, oe_reg, rd_next;

  assign sel = reg_sel_e'(bus_addr);

  mmgpio_regs #(.WIDTH(WIDTH), .HAS_DIR(HAS_DIR)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .sel(sel), .wdata(bus_wdata),
    .out_q(out_q), .dir_q(dir_q)
  );

  mmgpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(in_sync)
  );

  mmgpio_order #(.WIDTH(WIDTH), .REVERSE(MSB_FIRST)) u_in_order (
    .src(in_sync), .dst(in_reg)
  );

  // Per-bit "this bit drives" in register order.
  if (HAS_DIR) begin : g_drive
    assign drive_reg = DIR_IS_INPUT ? ~dir_q : dir_q;
    assign oe_reg    = drive_reg;
  end else begin : g_bidir
    assign drive_reg = '0;
    assign oe_reg    = '1;
  end

  mmgpio_order #(.WIDTH(WIDTH), .REVERSE(MSB_FIRST)) u_out_order (
    .src(out_q), .dst(pin_out)
  );

  mmgpio_order #(.WIDTH(WIDTH), .REVERSE(MSB_FIRST)) u_oe_order (
    .src(oe_reg), .dst(pin_oe)
  );

  always_comb begin
    case (sel)
      SEL_DATA: rd_next = (out_q & drive_reg) | (in_reg & ~drive_reg);
      SEL_DIR:  rd_next = dir_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/mmgpio_port_chk.sv
module mmgpio_port_chk #(
  parameter int unsigned WIDTH        = 8,
  parameter bit          DIR_IS_INPUT = 1'b0,
  parameter bit          MSB_FIRST    = 1'b0,
  parameter bit          HAS_DIR      = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] pin_in,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe
);
  function automatic logic [WIDTH-1:0] to_pins(input logic [WIDTH-1:0] r);
    logic [WIDTH-1:0] p;
    for (int i = 0; i < WIDTH; i++) p[i] = MSB_FIRST ? r[WIDTH-1-i] : r[i];
    return p;
  endfunction

  AST_RESET_OUT_ZERO: assert property (@(posedge clk)
    $past(rst) |-> pin_out == '0);  // R1

  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_addr == 2'd0 |=> pin_out == to_pins($past(bus_wdata)));  // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(pin_out));  // R2

  AST_SET_MASK: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_addr == 2'd1 |=>
      pin_out == ($past(pin_out) | to_pins($past(bus_wdata))));  // R3

  AST_CLR_MASK: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_addr == 2'd2 |=>
      pin_out == ($past(pin_out) & ~to_pins($past(bus_wdata))));  // R4

  AST_SETCLR_KEEP_OE: assert property (@(posedge clk) disable iff (rst)
    bus_wr && (bus_addr == 2'd1 || bus_addr == 2'd2) |=> $stable(pin_oe));  // R5

  AST_SETCLR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 2'd1 || bus_addr == 2'd2) |=> bus_rdata == '0);  // R5

  if (!HAS_DIR) begin : g_nodir
    AST_NODIR_ALL_OE: assert property (@(posedge clk) disable iff (rst)
      pin_oe == '1);  // R10
  end
endmodule

bind mmgpio_port mmgpio_port_chk #(
  .WIDTH(WIDTH), .DIR_IS_INPUT(DIR_IS_INPUT), .MSB_FIRST(MSB_FIRST), .HAS_DIR(HAS_DIR)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/mmgpio_port_test.sv
`timescale 1ns/1ps
module mmgpio_port_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] rd_a, rd_b, rd_c;
  logic [W-1:0] out_a, out_b, out_c;
  logic [W-1:0] oe_a, oe_b, oe_c;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  mmgpio_port #(.WIDTH(W), .DIR_IS_INPUT(0), .MSB_FIRST(0), .HAS_DIR(1)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_a), .pin_in(pin_in), .pin_out(out_a), .pin_oe(oe_a));

  mmgpio_port #(.WIDTH(W), .DIR_IS_INPUT(1), .MSB_FIRST(1), .HAS_DIR(1)) uut_rev (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_b), .pin_in(pin_in), .pin_out(out_b), .pin_oe(oe_b));

  mmgpio_port #(.WIDTH(W), .DIR_IS_INPUT(0), .MSB_FIRST(0), .HAS_DIR(0)) uut_nodir (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_c), .pin_in(pin_in), .pin_out(out_c), .pin_oe(oe_c));

  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] ex, m, k, d, o, pi;
    repeat (3) @(negedge clk);
    // R1 / R6 / R10: reset state
    check("R1 out", out_a, '0);
    check("R1 rdata", rd_a, '0);
    check("R6 oe out-polarity reset", oe_a, 8'h00);
    check("R6 oe in-polarity reset", oe_b, 8'hFF);
    check("R10 oe no-dir reset", oe_c, 8'hFF);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out after release", out_a, '0);

    // R2 / R3 / R4 / R9: exhaustive data sweep with derived masks
    for (int v = 0; v < 256; v++) begin
      bus_write(2'd0, W'(v));
      check("R2 data write", out_a, W'(v));
      check("R9 reversed data", out_b, rev(W'(v)));
      m = W'(v * 37 + 11);
      bus_write(2'd1, m);
      ex = W'(v) | m;
      check("R3 set mask", out_a, ex);
      check("R9 reversed set", out_b, rev(ex));
      k = W'(v * 91 + 5);
      bus_write(2'd2, k);
      ex = ex & ~k;
      check("R4 clear mask", out_a, ex);
      check("R9 reversed clear", out_b, rev(ex));
      @(negedge clk);
      check("R2 hold without write", out_a, ex);
    end

    // R6 / R9 / R10 / R11: exhaustive direction sweep
    for (int v = 0; v < 256; v++) begin
      d = W'(v);
      bus_write(2'd3, d);
      check("R6 oe out-polarity", oe_a, d);
      check("R6 R9 oe in-polarity reversed", oe_b, rev(~d));
      check("R10 oe no-dir", oe_c, 8'hFF);
      bus_read(2'd3);
      check("R11 dir readback", rd_a, d);
      check("R11 dir readback rev", rd_b, d);
      check("R10 dir reads zero", rd_c, 8'h00);
    end

    // R5: set/clear offsets read zero and leave direction alone
    bus_write(2'd3, 8'h5A);
    bus_write(2'd1, 8'hFF);
    bus_write(2'd2, 8'h0F);
    bus_read(2'd1);
    check("R5 set reads zero", rd_a, 8'h00);
    bus_read(2'd2);
    check("R5 clear reads zero", rd_a, 8'h00);
    check("R5 oe unchanged", oe_a, 8'h5A);
    bus_read(2'd3);
    check("R5 dir unchanged", rd_a, 8'h5A);

    // R7 / R9 / R10: mixed read-back
    for (int t = 0; t < 16; t++) begin
      o  = W'(t * 53 + 165);
      d  = W'(t * 29 + 15);
      pi = W'(t * 71 + 60);
      bus_write(2'd0, o);
      bus_write(2'd3, d);
      @(negedge clk);
      pin_in = pi;
      repeat (3) @(negedge clk);
      bus_read(2'd0);
      check("R7 mixed readback", rd_a, (o & d) | (pi & ~d));
      check("R7 R9 mixed readback rev", rd_b, (o & ~d) | (rev(pi) & d));
      check("R10 no-dir reads inputs", rd_c, pi);
    end

    // R8: input latency, all pins inputs on uut
    bus_write(2'd3, 8'h00);
    pin_in = 8'h00;
    repeat (4) @(negedge clk);
    bus_addr = 2'd0;
    pin_in = 8'hC3;
    @(posedge clk);           // edge k
    @(posedge clk);           // edge k+1
    @(negedge clk);
    check("R8 old value after k+1", rd_a, 8'h00);
    @(negedge clk);           // after edge k+2
    check("R8 new value after k+2", rd_a, 8'hC3);

    // R10: write to direction offset has no effect without a direction word
    bus_write(2'd3, 8'h00);
    check("R10 oe after dir write", oe_c, 8'hFF);
    bus_read(2'd0);
    check("R10 still reads inputs", rd_c, 8'hC3);

    finish_run();
  end
endmodule